// File: doc/BRIEF.md
# Alternating-Reload One-Shot Phase Timer

This block times one phase of a motor drive. A start trigger loads a reload value into a 16-bit down-counter. The counter then consumes exactly that many count-source pulses and stops. While it runs, a one-shot output is high. When it stops, the block raises a one-clock stop strobe and a one-clock interrupt request, and it flips a phase-polarity output between positive and negative.

The reload value comes from one of two setting registers, primary and secondary. A mode input decides how they are used. In single mode the primary value is used on every trigger. In alternating mode the triggers take the secondary value first, then the primary, and keep alternating. A setting of zero starts nothing and raises no interrupt.

The primary register takes a value in the cycle it is written. A secondary value takes effect only after two identical writes with a count-source pulse between them. This guard stops a single stray write from changing the alternate interval.

Top module: `phase_oneshot_timer`

## Requirements
- R1: With a reload value n (1 to 65535), `pulse_out` goes high in the cycle after the trigger. The counter stops on the clock edge that samples the n-th `cnt_en` pulse after the trigger, and `pulse_out` then falls.
- R2: A trigger that selects the value 0 leaves the counter idle. `pulse_out` stays low, and no stop strobe, interrupt or phase change follows.
- R3: When `alt_mode` is 0, every trigger loads the primary setting.
- R4: When `alt_mode` is 1, the triggers load secondary, primary, secondary, and so on, alternately.
- R5: After reset, and whenever `alt_mode` goes from 0 to 1, the next mode-1 trigger takes the secondary value. This also holds when the trigger falls in the same cycle that `alt_mode` rises.
- R6: `phase_pol` is 0 after reset. It inverts on every stop, and on nothing else.
- R7: `stop_stb` and `irq` are high together for exactly one clock, in the cycle after the edge on which the counter stops.
- R8: A secondary write is committed only if it repeats the value of the previous secondary write and a `cnt_en` pulse fell in a cycle strictly between the two writes. Any other secondary write only stages its value. The secondary setting is 0 after reset.
- R9: A trigger while the counter runs reloads it with the next selected value, and produces no stop strobe.
- R10: When a trigger and a `cnt_en` pulse fall in the same cycle, the trigger takes priority and that pulse is not counted.
- R11: `cnt_en` pulses while the counter is idle have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Count-source pulse, one clock wide |
| start_trig | input | 1 | Start trigger |
| alt_mode | input | 1 | 0: primary only, 1: alternate secondary/primary |
| pri_wr | input | 1 | Primary setting write strobe |
| pri_data | input | 16 | Primary setting write data |
| sec_wr | input | 1 | Secondary setting write strobe |
| sec_data | input | 16 | Secondary setting write data |
| pulse_out | output | 1 | One-shot output, high while counting |
| stop_stb | output | 1 | One-clock strobe when the counter stops |
| irq | output | 1 | One-clock interrupt request when the counter stops |
| phase_pol | output | 1 | Phase polarity, inverts on each stop |

## Verification
The trigger and the final count-source pulse can land in the same cycle. The bench provokes this by raising `start_trig` and `cnt_en` together while one count remains. It then expects no stop strobe and a full new interval, as R10 requires.

The rise of `alt_mode` can also coincide with a trigger. The bench provokes this and judges it by the measured interval length, which must equal the secondary value.

A behavioural reference model runs alongside the design. Its outputs are compared with the design's outputs on every clock.

// File: rtl/phase_tmr_pkg.sv
package phase_tmr_pkg;
    typedef enum logic {
        SRC_PRI = 1'b0,
        SRC_SEC = 1'b1
    } reload_src_e;
endpackage

// File: rtl/pot_sec_guard.sv
module pot_sec_guard #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic         sec_wr,
    input  logic [W-1:0] sec_data,
    output logic [W-1:0] sec_val
);
    typedef struct packed {
        logic [W-1:0] stage;
        logic         armed;
        logic         aged;
        logic [W-1:0] value;
    } guard_t;

    guard_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sec_wr) begin
            if (st_q.armed && st_q.aged && (sec_data == st_q.stage)) begin
                st_d.value = sec_data;
                st_d.armed = 1'b0;
                st_d.aged  = 1'b0;
            end else begin
                st_d.stage = sec_data;
                st_d.armed = 1'b1;
                st_d.aged  = 1'b0;
            end
        end else if (st_q.armed && cnt_en) begin
            st_d.aged = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sec_val = st_q.value;

    AST_SEC_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.value != $past(st_q.value)) |-> $past(sec_wr)); // R8
    AST_SEC_NEEDS_AGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sec_wr) && !$past(st_q.aged)) |-> $stable(st_q.value)); // R8
endmodule

// File: rtl/pot_reload_sel.sv
module pot_reload_sel
    import phase_tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_trig,
    input  logic         alt_mode,
    input  logic [W-1:0] pri_val,
    input  logic [W-1:0] sec_val,
    output logic [W-1:0] load_val
);
    typedef struct packed {
        logic sec_next;
        logic mode_prev;
    } sel_t;

    sel_t        st_d, st_q;
    logic        entering;
    reload_src_e src;

    always_comb begin
        st_d     = st_q;
        entering = alt_mode && !st_q.mode_prev;
        src      = (alt_mode && (entering || st_q.sec_next)) ? SRC_SEC : SRC_PRI;
        load_val = (src == SRC_SEC) ? sec_val : pri_val;
        st_d.mode_prev = alt_mode;
        if (start_trig && alt_mode) begin
            st_d.sec_next = (src == SRC_PRI);
        end else if (entering) begin
            st_d.sec_next = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sec_next: 1'b1, mode_prev: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    AST_ENTRY_PICKS_SEC: assert property (@(posedge clk) disable iff (!rst_n)
        (start_trig && alt_mode && !st_q.mode_prev) |-> (load_val == sec_val)); // R5
    AST_ALT_SWAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_trig && alt_mode && $past(start_trig) && $past(alt_mode)) |-> (src != $past(src))); // R4
endmodule

// File: rtl/pot_count_core.sv
module pot_count_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_trig,
    input  logic         cnt_en,
    input  logic [W-1:0] load_val,
    output logic         running,
    output logic         stop_stb,
    output logic         irq,
    output logic         phase_pol,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] LAST = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         run;
        logic         stb;
        logic         irq;
        logic         phase;
    } core_t;

    core_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        st_d.irq = 1'b0;
        if (start_trig) begin
            st_d.cnt = load_val;
            st_d.run = (load_val != '0);
        end else if (st_q.run && cnt_en) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt   = '0;
                st_d.run   = 1'b0;
                st_d.stb   = 1'b1;
                st_d.irq   = 1'b1;
                st_d.phase = ~st_q.phase;
            end else begin
                st_d.cnt = st_q.cnt - LAST;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign running   = st_q.run;
    assign stop_stb  = st_q.stb;
    assign irq       = st_q.irq;
    assign phase_pol = st_q.phase;
    assign count     = st_q.cnt;

    AST_ZERO_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start_trig && load_val == '0) |=> (!running && !stop_stb)); // R2
    AST_END_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cnt_en && !start_trig && count == LAST) |=> (stop_stb && !running)); // R1
    AST_PHASE_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_pol != $past(phase_pol)) |-> stop_stb); // R6
    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_stb |=> !stop_stb); // R7
    AST_TRIG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_trig && load_val != '0) |=> (running && count == $past(load_val) && !stop_stb)); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !start_trig) |=> (!running && !stop_stb && $stable(phase_pol))); // R11
endmodule

// File: rtl/phase_oneshot_timer.sv
module phase_oneshot_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic         start_trig,
    input  logic         alt_mode,
    input  logic         pri_wr,
    input  logic [W-1:0] pri_data,
    input  logic         sec_wr,
    input  logic [W-1:0] sec_data,
    output logic         pulse_out,
    output logic         stop_stb,
    output logic         irq,
    output logic         phase_pol
);
    logic [W-1:0] pri_d, pri_q;
    logic [W-1:0] sec_val;
    logic [W-1:0] load_val;
    logic [W-1:0] count;

    always_comb begin
        pri_d = pri_q;
        if (pri_wr) begin
            pri_d = pri_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pri_q <= '0;
        end else begin
            pri_q <= pri_d;
        end
    end

    pot_sec_guard #(.W(W)) i_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_en   (cnt_en),
        .sec_wr   (sec_wr),
        .sec_data (sec_data),
        .sec_val  (sec_val)
    );

    pot_reload_sel #(.W(W)) i_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_trig (start_trig),
        .alt_mode   (alt_mode),
        .pri_val    (pri_q),
        .sec_val    (sec_val),
        .load_val   (load_val)
    );

    pot_count_core #(.W(W)) i_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_trig (start_trig),
        .cnt_en     (cnt_en),
        .load_val   (load_val),
        .running    (pulse_out),
        .stop_stb   (stop_stb),
        .irq        (irq),
        .phase_pol  (phase_pol),
        .count      (count)
    );

    AST_MODE0_PRIMARY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_trig && !alt_mode && pri_q != '0) |=> (count == $past(pri_q))); // R3
    AST_IRQ_PAIRS_STB: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $rose(stop_stb)); // R7
endmodule

// File: tb/test_phase_oneshot_timer.sv
module test_phase_oneshot_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic        start_trig = 1'b0;
    logic        alt_mode = 1'b0;
    logic        pri_wr = 1'b0;
    logic [15:0] pri_data = '0;
    logic        sec_wr = 1'b0;
    logic [15:0] sec_data = '0;
    logic        pulse_out, stop_stb, irq, phase_pol;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    phase_oneshot_timer i_phase_oneshot_timer (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .start_trig(start_trig),
        .alt_mode(alt_mode), .pri_wr(pri_wr), .pri_data(pri_data),
        .sec_wr(sec_wr), .sec_data(sec_data), .pulse_out(pulse_out),
        .stop_stb(stop_stb), .irq(irq), .phase_pol(phase_pol)
    );

    // behavioural reference model
    int m_pri, m_sec, m_stage, m_cnt;
    bit m_armed, m_aged, m_secnext, m_prevmode, m_run, m_stb, m_phase;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pri = 0; m_sec = 0; m_stage = 0; m_cnt = 0;
            m_armed = 0; m_aged = 0; m_secnext = 1; m_prevmode = 0;
            m_run = 0; m_stb = 0; m_phase = 0;
        end else begin
            int v;
            bit fresh;
            fresh = alt_mode && !m_prevmode;
            m_stb = 0;
            if (start_trig) begin
                if (alt_mode && (fresh || m_secnext)) begin
                    v = m_sec; m_secnext = 0;
                end else begin
                    v = m_pri;
                    if (alt_mode) m_secnext = 1;
                end
                m_cnt = v;
                m_run = (v != 0);
            end else begin
                if (fresh) m_secnext = 1;
                if (m_run && cnt_en) begin
                    m_cnt = m_cnt - 1;
                    if (m_cnt == 0) begin
                        m_run = 0; m_stb = 1; m_phase = !m_phase;
                    end
                end
            end
            if (pri_wr) m_pri = int'(pri_data);
            if (sec_wr) begin
                if (m_armed && m_aged && int'(sec_data) == m_stage) begin
                    m_sec = m_stage; m_armed = 0; m_aged = 0;
                end else begin
                    m_stage = int'(sec_data); m_armed = 1; m_aged = 0;
                end
            end else if (m_armed && cnt_en) begin
                m_aged = 1;
            end
            m_prevmode = alt_mode;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (pulse_out !== m_run || stop_stb !== m_stb || irq !== m_stb || phase_pol !== m_phase) begin
                errors++;
                $display("FAIL model R1/R6/R7: act run=%0b stb=%0b irq=%0b ph=%0b exp run=%0b stb=%0b ph=%0b",
                         pulse_out, stop_stb, irq, phase_pol, m_run, m_stb, m_phase);
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic wr_pri(input int v);
        pri_wr = 1; pri_data = 16'(v); @(negedge clk); pri_wr = 0;
    endtask
    task automatic wr_sec(input int v);
        sec_wr = 1; sec_data = 16'(v); @(negedge clk); sec_wr = 0;
    endtask
    task automatic pulse_en;
        cnt_en = 1; @(negedge clk); cnt_en = 0;
    endtask
    task automatic trig;
        start_trig = 1; @(negedge clk); start_trig = 0;
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask
    task automatic measure(output int n);
        n = 0;
        while (n < 70000) begin
            cnt_en = 1; @(negedge clk); n++;
            if (stop_stb) break;
        end
        cnt_en = 0;
    endtask

    initial begin
        #(8 * 190000);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int n;
        bit ph;
        idle(3);
        rst_n = 1;
        @(negedge clk);
        check(pulse_out == 0 && stop_stb == 0 && irq == 0, "R7 reset outputs", int'(pulse_out), 0);
        check(phase_pol == 0, "R6 reset phase", int'(phase_pol), 0);

        // R11: enables while idle
        pulse_en(); pulse_en(); pulse_en();
        check(stop_stb == 0 && phase_pol == 0, "R11 idle enables", int'(phase_pol), 0);

        // R1/R3: mode 0, primary 3
        wr_pri(3); trig();
        check(pulse_out == 1, "R1 pulse high after trigger", int'(pulse_out), 1);
        measure(n);
        check(n == 3, "R1 interval length", n, 3);
        check(irq == 1 && stop_stb == 1, "R7 irq with stop", int'(irq), 1);
        check(phase_pol == 1, "R6 phase toggled", int'(phase_pol), 1);
        @(negedge clk);
        check(stop_stb == 0 && irq == 0, "R7 one clock strobe", int'(stop_stb), 0);
        trig(); measure(n);
        check(n == 3, "R3 primary reused", n, 3);
        check(phase_pol == 0, "R6 phase back", int'(phase_pol), 0);

        // R2: zero setting
        wr_pri(0); trig();
        check(pulse_out == 0, "R2 zero no start", int'(pulse_out), 0);
        pulse_en(); pulse_en(); pulse_en();
        check(stop_stb == 0 && irq == 0 && phase_pol == 0, "R2 zero no irq", int'(irq), 0);

        // R8: single write does not commit
        alt_mode = 1; @(negedge clk);
        wr_sec(5); trig();
        check(pulse_out == 0, "R8 single write ignored", int'(pulse_out), 0);
        wr_sec(5);
        pulse_en();
        wr_sec(5);
        alt_mode = 0; @(negedge clk);
        alt_mode = 1; @(negedge clk);
        wr_pri(4);
        trig(); measure(n);
        check(n == 5, "R8 committed secondary first R5", n, 5);
        trig(); measure(n);
        check(n == 4, "R4 primary second", n, 4);
        trig(); measure(n);
        check(n == 5, "R4 secondary third", n, 5);

        // R8: differing values rejected
        wr_sec(7); pulse_en(); wr_sec(8); pulse_en(); wr_sec(7);
        trig(); measure(n);
        check(n == 4, "R4 primary fourth", n, 4);
        trig(); measure(n);
        check(n == 5, "R8 mismatched writes rejected", n, 5);

        // R5: mode entry in same cycle as trigger
        alt_mode = 0; @(negedge clk);
        alt_mode = 1; start_trig = 1; @(negedge clk); start_trig = 0;
        measure(n);
        check(n == 5, "R5 entry with trigger picks secondary", n, 5);

        // R9: retrigger while running
        alt_mode = 0; wr_pri(6); trig();
        pulse_en(); pulse_en();
        trig();
        check(stop_stb == 0 && pulse_out == 1, "R9 retrigger no strobe", int'(stop_stb), 0);
        measure(n);
        check(n == 6, "R9 full reload after retrigger", n, 6);

        // R10: trigger and last enable in the same cycle
        wr_pri(2); trig(); pulse_en();
        ph = phase_pol;
        start_trig = 1; cnt_en = 1; @(negedge clk); start_trig = 0; cnt_en = 0;
        check(stop_stb == 0 && pulse_out == 1 && phase_pol == ph, "R10 trigger wins", int'(stop_stb), 0);
        measure(n);
        check(n == 2, "R10 interval restarted", n, 2);

        // R1: maximum setting
        wr_pri(65535); trig(); measure(n);
        check(n == 65535, "R1 maximum interval", n, 65535);

        idle(3);
        finish_run();
    end
endmodule